// File: doc/BRIEF.md
# Dual-Word Register-Offset Store Unit

This block executes one store-dual instruction whose address uses a register offset. A pipeline stage supplies the 32-bit instruction word together with a start pulse, a flag that says whether the instruction's condition passed, and the current endian mode. The block decodes the register numbers combinationally onto four select outputs. In the same cycle, the register file feeds back the base value, the index value and the two data values.

The block works out the offset address as the base plus or minus the index, modulo 2^32. The access address is either that offset address or the unmodified base, depending on the indexing mode. The block then stores the two data words. If the access address is 8-byte aligned, it issues one 64-bit write with the two words placed in endian order. Otherwise it issues two 32-bit writes in sequence, each paced by a valid/ready handshake.

When the mode calls for it, the block writes the offset address back to the base register one cycle after the last write is accepted. It also flags encodings whose architectural result is unpredictable. It does not choose among the possible outcomes for those encodings.

States:
- `ST_IDLE` waits for start.
- `ST_DWORD` holds the 64-bit write.
- `ST_WORD_LO` and `ST_WORD_HI` hold the first and second word writes.
- `ST_FINISH` reports done and drives the optional writeback.

Transitions:
- **launch-aligned**: `ST_IDLE` to `ST_DWORD`.
- **launch-split**: `ST_IDLE` to `ST_WORD_LO`.
- **dword-accepted**: `ST_DWORD` to `ST_FINISH`.
- **low-accepted**: `ST_WORD_LO` to `ST_WORD_HI`.
- **high-accepted**: `ST_WORD_HI` to `ST_FINISH`.
- **retire**: `ST_FINISH` to `ST_IDLE`.

Top module: `dsu_top`

## Requirements
- R1: An instruction matches only when bits 31:28 differ from 1111, bits 27:25 are 000, bit 22 is 0, bit 20 is 0 and bits 7:4 are 1111. A start with a non-matching word raises done in the same cycle, with no write, no writeback and unpred low.
- R2: For a matching word, unpred is high when any of these holds:
  - Rt (bits 15:12) is odd.
  - P (bit 24) is 0 and W (bit 21) is 1.
  - Rt+1 is 15, or Rm (bits 3:0) is 15.
  - Writeback is enabled and Rn (bits 19:16) equals 15, Rt or Rt+1.
  - Bits 11:8 are nonzero.
  
  In every other case unpred is low, and a nonzero bits 11:8 field does not stop the match.
- R3: The offset address is base+index when U (bit 23) is 1 and base-index when U is 0, modulo 2^32. The access address is the offset address when P is 1 and the base when P is 0.
- R4: An access address with bits 2:0 equal to zero gives exactly one write with mem_be = 8'hFF. In little-endian mode, the first data register fills mem_wdata[31:0] and the second fills mem_wdata[63:32].
- R5: In big-endian mode the 64-bit write places the first data register in mem_wdata[63:32] and the second in mem_wdata[31:0].
- R6: Any other access address gives two writes with mem_be = 8'h0F and the word in mem_wdata[31:0]. The first write carries the first data register at the access address; the second carries the second data register at the access address + 4, modulo 2^32.
- R7: The second word write appears only after the first has been accepted (mem_valid and mem_ready high at an edge). A pending write keeps its address, data and byte enables stable until it is accepted.
- R8: Writeback is enabled when P is 0 or W is 1. In that case wb_valid is high for exactly one cycle, the cycle after the last write is accepted, with wb_reg = Rn and wb_data = offset address; done is high in that same cycle.
- R9: A start with cond_pass low raises done in the same cycle and produces no write and no writeback.
- R10: The selects follow the instruction word combinationally: rn_sel = Rn, rm_sel = Rm, rt_sel = Rt, rt2_sel = Rt+1 (4-bit).
- R11: A start pulse while busy is high has no effect. After done, busy is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition of the instruction passed |
| big_endian | input | 1 | Endian mode for the 64-bit write |
| rn_sel | output | 4 | Base register number |
| rm_sel | output | 4 | Index register number |
| rt_sel | output | 4 | First data register number |
| rt2_sel | output | 4 | Second data register number |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| data0_val | input | 32 | First data register value |
| data1_val | input | 32 | Second data register value |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Instruction retires this cycle |
| unpred | output | 1 | Unpredictable encoding detected |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Write request accepted |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables |
| wb_valid | output | 1 | Base writeback strobe |
| wb_reg | output | 4 | Writeback register number |
| wb_data | output | 32 | Writeback value |

## Verification
The assertions assume that `start` comes from an upstream stage that keeps `instr` and the register values steady for the cycle of the pulse. They also assume that `mem_ready` is a plain acceptance strobe and never has to be held across cycles by the block.

The stimulus drives all inputs half a cycle away from the active edge and raises `start` for a single cycle. It varies `mem_ready` between always-ready and a one-in-three pattern, so that the write-hold and ordering properties are exercised under back-pressure. The extra start pulse issued mid-operation is there only to show that the pulse is ignored; it does not break the single-cycle assumption for a real launch.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

    localparam int INSTR_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DWORD,
        ST_WORD_LO,
        ST_WORD_HI,
        ST_FINISH
    } dsu_state_e;

    typedef struct packed {
        logic       hit;
        logic       pre;
        logic       up;
        logic       wr;
        logic       wb;
        logic [3:0] rn;
        logic [3:0] rt;
        logic [3:0] rt2;
        logic [3:0] rm;
        logic       unpred;
    } dsu_dec_t;

endpackage

// File: rtl/dsu_decode.sv
module dsu_decode
    import dsu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dsu_dec_t           dec
);

    always_comb begin
        dec.hit = (instr[31:28] != 4'hF) && (instr[27:25] == 3'b000)
                  && !instr[22] && !instr[20] && (instr[7:4] == 4'hF);
        dec.pre = instr[24];
        dec.up  = instr[23];
        dec.wr  = instr[21];
        dec.rn  = instr[19:16];
        dec.rt  = instr[15:12];
        dec.rm  = instr[3:0];
        dec.rt2 = instr[15:12] + 4'd1;
        dec.wb  = !instr[24] || instr[21];
        dec.unpred = dec.hit && (
                        dec.rt[0]
                     || (!dec.pre && dec.wr)
                     || (dec.rt2 == 4'hF)
                     || (dec.rm == 4'hF)
                     || (dec.wb && ((dec.rn == 4'hF) || (dec.rn == dec.rt) || (dec.rn == dec.rt2)))
                     || (instr[11:8] != 4'h0));
    end

endmodule

// File: rtl/dsu_agen.sv
module dsu_agen #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] index,
    input  logic          up,
    input  logic          pre,
    output logic [DW-1:0] offs_addr,
    output logic [DW-1:0] acc_addr,
    output logic [DW-1:0] next_addr,
    output logic          aligned
);

    localparam int STEP = DW / 8;
    localparam int ALB  = $clog2(2 * STEP);

    always_comb begin
        offs_addr = up ? (base + index) : (base - index);
        acc_addr  = pre ? offs_addr : base;
        next_addr = acc_addr + DW'(STEP);
        aligned   = (acc_addr[ALB-1:0] == '0);
    end

endmodule

// File: rtl/dsu_top.sv
module dsu_top
    import dsu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [INSTR_W-1:0]   instr,
    input  logic                 cond_pass,
    input  logic                 big_endian,
    output logic [3:0]           rn_sel,
    output logic [3:0]           rm_sel,
    output logic [3:0]           rt_sel,
    output logic [3:0]           rt2_sel,
    input  logic [DW-1:0]        base_val,
    input  logic [DW-1:0]        index_val,
    input  logic [DW-1:0]        data0_val,
    input  logic [DW-1:0]        data1_val,
    output logic                 busy,
    output logic                 done,
    output logic                 unpred,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [DW-1:0]        mem_addr,
    output logic [2*DW-1:0]      mem_wdata,
    output logic [(2*DW)/8-1:0]  mem_be,
    output logic                 wb_valid,
    output logic [3:0]           wb_reg,
    output logic [DW-1:0]        wb_data
);

    localparam int MW = 2 * DW;
    localparam int BW = MW / 8;
    localparam logic [BW-1:0] BE_ALL = '1;
    localparam logic [BW-1:0] BE_LO  = {{(BW/2){1'b0}}, {(BW/2){1'b1}}};

    dsu_state_e state_q, state_d;
    dsu_dec_t   dec;

    logic [DW-1:0] offs_c, acc_c, next_c;
    logic          aligned_c;
    logic          launch;

    logic [DW-1:0] offs_q, acc_q, next_q, d0_q, d1_q;
    logic          bigend_q, wb_q;
    logic [3:0]    rn_q;

    dsu_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    dsu_agen #(.DW(DW)) u_agen (
        .base      (base_val),
        .index     (index_val),
        .up        (dec.up),
        .pre       (dec.pre),
        .offs_addr (offs_c),
        .acc_addr  (acc_c),
        .next_addr (next_c),
        .aligned   (aligned_c)
    );

    assign rn_sel  = dec.rn;
    assign rm_sel  = dec.rm;
    assign rt_sel  = dec.rt;
    assign rt2_sel = dec.rt2;
    assign unpred  = dec.unpred;

    assign launch = (state_q == ST_IDLE) && start && dec.hit && cond_pass;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch) state_d = aligned_c ? ST_DWORD : ST_WORD_LO;
            ST_DWORD:   if (mem_ready) state_d = ST_FINISH;
            ST_WORD_LO: if (mem_ready) state_d = ST_WORD_HI;
            ST_WORD_HI: if (mem_ready) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            offs_q   <= '0;
            acc_q    <= '0;
            next_q   <= '0;
            d0_q     <= '0;
            d1_q     <= '0;
            bigend_q <= 1'b0;
            wb_q     <= 1'b0;
            rn_q     <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                offs_q   <= offs_c;
                acc_q    <= acc_c;
                next_q   <= next_c;
                d0_q     <= data0_val;
                d1_q     <= data1_val;
                bigend_q <= big_endian;
                wb_q     <= dec.wb;
                rn_q     <= dec.rn;
            end
        end
    end

    // Outputs per state
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = 1'b0;
        mem_valid = 1'b0;
        mem_addr  = acc_q;
        mem_wdata = '0;
        mem_be    = '0;
        wb_valid  = 1'b0;
        wb_reg    = rn_q;
        wb_data   = offs_q;
        unique case (state_q)
            ST_IDLE: begin
                done = start && (!dec.hit || !cond_pass);
            end
            ST_DWORD: begin
                mem_valid = 1'b1;
                mem_be    = BE_ALL;
                mem_wdata = bigend_q ? {d0_q, d1_q} : {d1_q, d0_q};
            end
            ST_WORD_LO: begin
                mem_valid = 1'b1;
                mem_be    = BE_LO;
                mem_wdata = {{DW{1'b0}}, d0_q};
            end
            ST_WORD_HI: begin
                mem_valid = 1'b1;
                mem_addr  = next_q;
                mem_be    = BE_LO;
                mem_wdata = {{DW{1'b0}}, d1_q};
            end
            ST_FINISH: begin
                done     = 1'b1;
                wb_valid = wb_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dsu_checker.sv
module dsu_checker #(
    parameter int DW = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                cond_pass,
    input logic                busy,
    input logic                done,
    input logic                mem_valid,
    input logic                mem_ready,
    input logic [DW-1:0]       mem_addr,
    input logic [2*DW-1:0]     mem_wdata,
    input logic [(2*DW)/8-1:0] mem_be,
    input logic                wb_valid
);

    localparam int BW = (2 * DW) / 8;
    localparam logic [BW-1:0] BE_ALL = '1;
    localparam logic [BW-1:0] BE_LO  = {{(BW/2){1'b0}}, {(BW/2){1'b1}}};
    localparam int ALB = $clog2(BW);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_wdata) && $stable(mem_be));

    assert_dword_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && (mem_be == BE_ALL) |-> (mem_addr[ALB-1:0] == '0));

    assert_be_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_be == BE_ALL) || (mem_be == BE_LO));

    assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done && !mem_valid);

    assert_wb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    assert_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !cond_pass |-> done && !mem_valid);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy && !mem_valid);

endmodule

bind dsu_top dsu_checker #(.DW(DW)) u_dsu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cond_pass (cond_pass),
    .busy      (busy),
    .done      (done),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .wb_valid  (wb_valid)
);

// File: tb/dsu_top_bench.sv
module dsu_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        cond_pass = 1'b1;
    logic        big_endian = 1'b0;
    logic [3:0]  rn_sel, rm_sel, rt_sel, rt2_sel;
    logic [31:0] base_val = '0, index_val = '0, data0_val = '0, data1_val = '0;
    logic        busy, done, unpred, mem_valid, wb_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr, wb_data;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_be;
    logic [3:0]  wb_reg;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rdy_cnt = 0;
    bit stall = 1'b0;

    typedef struct {
        logic [31:0] addr;
        logic [63:0] data;
        logic [7:0]  be;
        string       tag;
    } wr_item_t;

    typedef struct {
        logic [3:0]  rn;
        logic [31:0] val;
    } wb_item_t;

    wr_item_t wr_q[$];
    wb_item_t wb_q[$];

    always #4 clk = ~clk;

    dsu_top u_dsu_top (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .cond_pass(cond_pass), .big_endian(big_endian),
        .rn_sel(rn_sel), .rm_sel(rm_sel), .rt_sel(rt_sel), .rt2_sel(rt2_sel),
        .base_val(base_val), .index_val(index_val),
        .data0_val(data0_val), .data1_val(data1_val),
        .busy(busy), .done(done), .unpred(unpred),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    // Ready pattern, changed away from the active edge
    always @(negedge clk) begin
        rdy_cnt++;
        mem_ready <= stall ? (rdy_cnt % 3 == 0) : 1'b1;
    end

    // Monitor: compare accepted writes and writebacks with the scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (mem_valid && mem_ready) begin
                if (wr_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected write", {32'b0, mem_addr}, 64'h0);
                end else begin
                    wr_item_t e;
                    e = wr_q.pop_front();
                    chk(mem_addr == e.addr, {e.tag, " R3 addr"}, {32'b0, mem_addr}, {32'b0, e.addr});
                    chk(mem_wdata == e.data, {e.tag, " data"}, mem_wdata, e.data);
                    chk(mem_be == e.be, {e.tag, " be"}, {56'b0, mem_be}, {56'b0, e.be});
                end
            end
            if (wb_valid) begin
                if (wb_q.size() == 0 || wr_q.size() != 0) begin
                    chk(1'b0, "R8 early or unexpected writeback", {28'b0, wb_reg, wb_data}, 64'h0);
                end else begin
                    wb_item_t w;
                    w = wb_q.pop_front();
                    chk(wb_reg == w.rn && done, "R8 wb reg", {59'b0, done, wb_reg}, {59'b1, w.rn});
                    chk(wb_data == w.val, "R8 wb data", {32'b0, wb_data}, {32'b0, w.val});
                end
            end
        end
    end

    function automatic logic [31:0] enc(input logic [3:0] cnd, input bit p, input bit u, input bit w,
                                        input logic [3:0] rn, input logic [3:0] rt,
                                        input logic [3:0] sbz, input logic [3:0] rm);
        return {cnd, 3'b000, p, u, 1'b0, w, 1'b0, rn, rt, sbz, 4'hF, rm};
    endfunction

    // Driver: build expectations from the requirements, then launch
    task automatic run_op(input logic [31:0] ins, input bit cp, input bit be,
                          input logic [31:0] b, input logic [31:0] x,
                          input logic [31:0] d0, input logic [31:0] d1, input bit poke_busy);
        bit hit, p, u, w, wbk;
        logic [31:0] offs, acc;
        hit = (ins[31:28] != 4'hF) && (ins[27:25] == 3'b000) && !ins[22] && !ins[20] && (ins[7:4] == 4'hF);
        p = ins[24]; u = ins[23]; w = ins[21];
        wbk = !p || w;
        offs = u ? b + x : b - x;
        acc = p ? offs : b;
        if (hit && cp) begin
            if (acc[2:0] == 3'b000)
                wr_q.push_back('{acc, be ? {d0, d1} : {d1, d0}, 8'hFF, be ? "R5" : "R4"});
            else begin
                wr_q.push_back('{acc, {32'b0, d0}, 8'h0F, "R6 first"});
                wr_q.push_back('{acc + 32'd4, {32'b0, d1}, 8'h0F, "R6 second"});
            end
            if (wbk) wb_q.push_back('{ins[19:16], offs});
        end
        @(negedge clk);
        instr = ins; cond_pass = cp; big_endian = be;
        base_val = b; index_val = x; data0_val = d0; data1_val = d1; start = 1'b1;
        #2;
        chk({rn_sel, rm_sel, rt_sel, rt2_sel} == {ins[19:16], ins[3:0], ins[15:12], ins[15:12] + 4'd1},
            "R10 selects", {48'b0, rn_sel, rm_sel, rt_sel, rt2_sel},
            {48'b0, ins[19:16], ins[3:0], ins[15:12], ins[15:12] + 4'd1});
        if (!hit) begin
            chk(done && !mem_valid && !unpred, "R1 nonmatch", {61'b0, done, mem_valid, unpred}, 64'h4);
        end else if (!cp) begin
            chk(done && !mem_valid, "R9 cond fail", {62'b0, done, mem_valid}, 64'h2);
        end
        @(negedge clk);
        start = 1'b0;
        if (hit && cp) begin
            if (poke_busy) begin
                #1;
                instr = enc(4'hE, 1'b1, 1'b1, 1'b0, 4'h1, 4'h4, 4'h0, 4'h2);
                base_val = 32'h0000_0100;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            for (int i = 0; i < 200; i++) begin
                #2;
                if (done) break;
                @(negedge clk);
            end
            @(negedge clk);
            #2;
            chk(!busy, "R11 idle after done", {63'b0, busy}, 64'h0);
        end else begin
            repeat (3) @(negedge clk);
        end
        chk(wr_q.size() == 0 && wb_q.size() == 0, "R7 R8 all items seen",
            wr_q.size() + wb_q.size(), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !mem_valid && !done && !wb_valid, "R11 reset state",
            {60'b0, busy, mem_valid, done, wb_valid}, 64'h0);
        rst_n = 1'b1;

        // R4: offset mode, aligned, little-endian, no writeback
        run_op(enc(4'hE, 1, 1, 0, 4'h1, 4'h2, 4'h0, 4'h3), 1, 0,
               32'h0000_1000, 32'h0000_0010, 32'hAAAA_0001, 32'hBBBB_0002, 0);
        // R5 R8: pre-index subtract, aligned, big-endian, writeback
        run_op(enc(4'h0, 1, 0, 1, 4'h5, 4'h2, 4'h0, 4'h6), 1, 1,
               32'h0000_2000, 32'h0000_0008, 32'h1111_2222, 32'h3333_4444, 0);
        // R6 R8 R3: post-index, unaligned base, writeback of base+index
        run_op(enc(4'hE, 0, 1, 0, 4'h7, 4'h4, 4'h0, 4'h8), 1, 0,
               32'h0000_3004, 32'h0000_0020, 32'hCAFE_0000, 32'hBEEF_0001, 0);
        // R6 R3: second address wraps past 2^32
        stall = 1'b1;
        run_op(enc(4'hE, 1, 1, 1, 4'h9, 4'h0, 4'h0, 4'hA), 1, 0,
               32'hFFFF_FFF8, 32'h0000_0004, 32'h0123_4567, 32'h89AB_CDEF, 0);
        // R3 R7: subtract with borrow, unaligned, under back-pressure
        run_op(enc(4'hE, 1, 0, 0, 4'h3, 4'h6, 4'h0, 4'h1), 1, 1,
               32'h0000_0004, 32'h0000_0010, 32'h5555_AAAA, 32'h6666_BBBB, 0);
        // R11: start while busy is ignored
        run_op(enc(4'hE, 1, 1, 0, 4'h2, 4'h8, 4'h0, 4'h3), 1, 0,
               32'h0000_4000, 32'h0000_0000, 32'h7777_0000, 32'h8888_0000, 1);
        stall = 1'b0;
        // R9: condition failed
        run_op(enc(4'hE, 0, 1, 0, 4'h1, 4'h2, 4'h0, 4'h3), 0, 0,
               32'h0000_5000, 32'h4, 32'h1, 32'h2, 0);
        // R1: cond 1111 and bit 20 set do not match
        run_op(enc(4'hF, 1, 1, 0, 4'h1, 4'h2, 4'h0, 4'h3), 1, 0,
               32'h0000_6000, 32'h0, 32'h1, 32'h2, 0);
        run_op(enc(4'hE, 1, 1, 0, 4'h1, 4'h2, 4'h0, 4'h3) | 32'h0010_0000, 1, 0,
               32'h0000_6000, 32'h0, 32'h1, 32'h2, 0);

        // R2: unpredictable detection
        @(negedge clk);
        instr = enc(4'hE, 1, 1, 0, 4'h1, 4'h2, 4'h0, 4'h3); #1;
        chk(!unpred, "R2 clean", {63'b0, unpred}, 64'h0);
        instr = enc(4'hE, 1, 1, 0, 4'h1, 4'h3, 4'h0, 4'h5); #1;
        chk(unpred, "R2 odd Rt", {63'b0, unpred}, 64'h1);
        instr = enc(4'hE, 0, 1, 1, 4'h1, 4'h2, 4'h0, 4'h5); #1;
        chk(unpred, "R2 P0 W1", {63'b0, unpred}, 64'h1);
        instr = enc(4'hE, 1, 1, 0, 4'h1, 4'hE, 4'h0, 4'h5); #1;
        chk(unpred, "R2 Rt 14", {63'b0, unpred}, 64'h1);
        instr = enc(4'hE, 1, 1, 0, 4'h1, 4'h2, 4'h0, 4'hF); #1;
        chk(unpred, "R2 Rm 15", {63'b0, unpred}, 64'h1);
        instr = enc(4'hE, 1, 1, 1, 4'h3, 4'h2, 4'h0, 4'h5); #1;
        chk(unpred, "R2 wb Rn eq Rt2", {63'b0, unpred}, 64'h1);
        instr = enc(4'hE, 1, 1, 0, 4'h3, 4'h2, 4'h0, 4'h5); #1;
        chk(!unpred, "R2 no wb Rn eq Rt2", {63'b0, unpred}, 64'h0);
        instr = enc(4'hE, 0, 1, 0, 4'hF, 4'h2, 4'h0, 4'h5); #1;
        chk(unpred, "R2 wb Rn 15", {63'b0, unpred}, 64'h1);
        instr = enc(4'hE, 1, 1, 0, 4'h1, 4'h2, 4'h4, 4'h5); #1;
        chk(unpred, "R2 sbz field", {63'b0, unpred}, 64'h1);
        // R2: nonzero bits 11:8 still match and execute
        run_op(enc(4'hE, 1, 1, 0, 4'h1, 4'h2, 4'h9, 4'h3), 1, 0,
               32'h0000_7000, 32'h0000_0008, 32'hDEAD_0000, 32'hF00D_0000, 0);

        finish_run();
    end

endmodule